// File: doc/BRIEF.md
# Double-Buffered DAC Register Front End

This block is the clocked digital front end of a 12-bit voltage-output converter. A microprocessor-style bus drives a parallel data word and four active-low strobes: select, write, load and zero. A fast system clock samples every strobe. The block keeps two registers. The input register takes the bus word while select and write are both low. The DAC register takes the input register while load is low. The DAC register drives the converter code. The block also gives a signed view of that code for bipolar ranges.

Each strobe first passes through a synchronizer. Every register acts on the synchronized strobes, so each path has a fixed latency in clock cycles. Load does not depend on write. Holding select, write and load low together lets the bus flow through to the code. The zero strobe has two effects, depending on the register state:
- When both registers follow their inputs, it overrides the code to zero only for as long as it is low.
- When the DAC register is holding, the zero stays in place until a later load.

Two more outputs are provided. An update pulse marks each change of the code. A violation pulse flags a load that ends too soon after a write it overlapped.

The input register runs a two-state machine:
- `IR_OPEN`: select and write are both low.
- `IR_HOLD`: any other strobe state.

The DAC register runs a three-state machine. Zero has priority over load.
- `DR_CLEAR`: zero is low.
- `DR_TRACK`: load is low and zero is high.
- `DR_HOLD`: any other strobe state.

The overlap monitor moves between three states:
- `HM_IDLE` goes to `HM_OVERLAP` when a write and a load are both active.
- `HM_OVERLAP` goes to `HM_TAIL` when the write ends while load stays low. It starts a gap count at 1.
- `HM_OVERLAP` goes to `HM_IDLE` when load ends. If the write ends in the same cycle, it flags a violation.
- `HM_TAIL` goes back to `HM_OVERLAP` when the write restarts.
- `HM_TAIL` goes to `HM_IDLE` when load rises. It flags a violation if the gap count is below `HOLD_MIN`.
- `HM_TAIL` also goes to `HM_IDLE` once the gap count reaches `HOLD_MIN`. It counts up by one each cycle until then.

Top module: `dbdac_front`

## Requirements
- R1: After reset, `code_o` is 0, `bip_o` is -2048, and `upd_o` and `viol_o` are low.
- R2: The input register follows `bus_i` only while `sel_n` and `wstb_n` are both low. It keeps its last value once either strobe rises. A write with only one of the two strobes low changes nothing, and later bus changes are ignored.
- R3: While `load_n` is high, `code_o` stays unchanged whatever happens on the bus, select or write. When `load_n` goes low with the input register already settled, `code_o` takes the input register value after the fourth rising edge.
- R4: While `zero_n` is low, the DAC register is forced to 0, with priority over load. `code_o` reads 0 after the fourth rising edge that samples `zero_n` low. After the third edge it still shows the old value.
- R5: If zero is released while select, write and load are all low, `code_o` goes back to the bus word. If zero pulses while load is high, `code_o` stays 0 until a later load.
- R6: `bip_o` is the two's-complement reading of `code_o` with bit 11 as the MSB: `code_o` minus 2048. So code 2048 gives 0, code 0 gives -2048 and code 4095 gives 2047.
- R7: `upd_o` is high for exactly those cycles in which `code_o` differs from its value in the previous cycle.
- R8: `viol_o` pulses for one cycle when load rises fewer than `HOLD_MIN` (default 4) clocks after the end of a write it overlapped. A gap of `HOLD_MIN` or more, or a load that did not overlap a write, gives no pulse.
- R9: With select, write and load all low, a new bus word reaches `code_o` after the fifth rising edge. After the fourth edge the old code is still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 12 | Parallel data word |
| sel_n | input | 1 | Active-low select |
| wstb_n | input | 1 | Active-low write strobe |
| load_n | input | 1 | Active-low transfer from the input register to the DAC register |
| zero_n | input | 1 | Active-low zero override of the DAC register |
| code_o | output | 12 | DAC register contents, i.e. the converter code |
| bip_o | output | 12 | Signed bipolar view of the code |
| upd_o | output | 1 | One-cycle pulse on each change of the code |
| viol_o | output | 1 | One-cycle pulse on a load hold violation |

## Verification
The assertions check four things on every cycle:
- the bipolar mapping;
- the tie between `upd_o` and code changes;
- that the code stays still when load and zero were both inactive one latency window earlier;
- that a zero seen one window earlier has cleared the code, and that the violation flag never lasts two cycles.

Only the bench scenarios can show the rest. These cover the following:
- the exact edge at which a flow-through word or a zero lands;
- the difference between a momentary and a persistent zero;
- that writes missing a strobe and bus changes after a write are ignored;
- the violation thresholds at gaps just below and at `HOLD_MIN`.

// File: rtl/dbdac_pkg.sv
package dbdac_pkg;

    typedef enum logic {
        IR_HOLD,
        IR_OPEN
    } in_mode_e;

    typedef enum logic [1:0] {
        DR_HOLD,
        DR_TRACK,
        DR_CLEAR
    } dac_mode_e;

    typedef enum logic [1:0] {
        HM_IDLE,
        HM_OVERLAP,
        HM_TAIL
    } hold_mon_e;

    // Synchronized strobe bundle, all active low.
    typedef struct packed {
        logic sel_n;
        logic wstb_n;
        logic load_n;
        logic zero_n;
    } strobes_t;

endpackage

// File: rtl/dbdac_sync.sv
module dbdac_sync #(
    parameter int             WIDTH   = 4,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= RST_VAL;
            end
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dbdac_regs.sv
module dbdac_regs
    import dbdac_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] bus_i,
    input  logic              wr_open,
    input  logic              ld_low,
    input  logic              clr_low,
    output logic [CODE_W-1:0] code_o,
    output logic              upd_o
);

    in_mode_e          in_state_q, in_state_d;
    dac_mode_e         dac_state_q, dac_state_d;
    logic [CODE_W-1:0] in_q, in_d;
    logic [CODE_W-1:0] dac_q, dac_d;
    logic              upd_q;

    // Next mode from the synchronized strobes; zero outranks load.
    always_comb begin
        in_state_d = wr_open ? IR_OPEN : IR_HOLD;
        if (clr_low) begin
            dac_state_d = DR_CLEAR;
        end else if (ld_low) begin
            dac_state_d = DR_TRACK;
        end else begin
            dac_state_d = DR_HOLD;
        end
    end

    // State registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_state_q  <= IR_HOLD;
            dac_state_q <= DR_HOLD;
        end else begin
            in_state_q  <= in_state_d;
            dac_state_q <= dac_state_d;
        end
    end

    // Register contents by mode.
    always_comb begin
        in_d = in_q;
        unique case (in_state_q)
            IR_OPEN: in_d = bus_i;
            IR_HOLD: in_d = in_q;
            default: in_d = in_q;
        endcase

        dac_d = dac_q;
        unique case (dac_state_q)
            DR_CLEAR: dac_d = '0;
            DR_TRACK: dac_d = in_q;
            DR_HOLD:  dac_d = dac_q;
            default:  dac_d = dac_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q  <= '0;
            dac_q <= '0;
            upd_q <= 1'b0;
        end else begin
            in_q  <= in_d;
            dac_q <= dac_d;
            upd_q <= (dac_d != dac_q);
        end
    end

    assign code_o = dac_q;
    assign upd_o  = upd_q;

endmodule

// File: rtl/dbdac_hold_mon.sv
module dbdac_hold_mon
    import dbdac_pkg::*;
#(
    parameter int HOLD_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_open,
    input  logic ld_low,
    output logic viol_o
);

    localparam int CNT_W = $clog2(HOLD_MIN + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_MIN);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    hold_mon_e         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              flag_q, flag_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= HM_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        flag_d = 1'b0;
        unique case (st_q)
            HM_IDLE: begin
                if (wr_open && ld_low) begin
                    st_d = HM_OVERLAP;
                end
            end
            HM_OVERLAP: begin
                if (!wr_open) begin
                    if (!ld_low) begin
                        flag_d = 1'b1;
                        st_d   = HM_IDLE;
                    end else begin
                        st_d  = HM_TAIL;
                        cnt_d = ONE;
                    end
                end else if (!ld_low) begin
                    st_d = HM_IDLE;
                end
            end
            HM_TAIL: begin
                if (wr_open && ld_low) begin
                    st_d  = HM_OVERLAP;
                    cnt_d = '0;
                end else if (!ld_low) begin
                    flag_d = (cnt_q < LIMIT);
                    st_d   = HM_IDLE;
                end else if (cnt_q >= LIMIT) begin
                    st_d = HM_IDLE;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            default: st_d = HM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    assign viol_o = flag_q;

endmodule

// File: rtl/dbdac_front.sv
module dbdac_front
    import dbdac_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_MIN    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CODE_W-1:0]        bus_i,
    input  logic                     sel_n,
    input  logic                     wstb_n,
    input  logic                     load_n,
    input  logic                     zero_n,
    output logic [CODE_W-1:0]        code_o,
    output logic signed [CODE_W-1:0] bip_o,
    output logic                     upd_o,
    output logic                     viol_o
);

    localparam int STB_W = $bits(strobes_t);
    localparam int MSB   = CODE_W - 1;

    strobes_t raw_stb, syn_stb;
    logic     wr_open, ld_low, clr_low;

    always_comb begin
        raw_stb.sel_n  = sel_n;
        raw_stb.wstb_n = wstb_n;
        raw_stb.load_n = load_n;
        raw_stb.zero_n = zero_n;
    end

    dbdac_sync #(
        .WIDTH  (STB_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL({STB_W{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_stb),
        .q_o  (syn_stb)
    );

    assign wr_open = !syn_stb.sel_n && !syn_stb.wstb_n;
    assign ld_low  = !syn_stb.load_n;
    assign clr_low = !syn_stb.zero_n;

    dbdac_regs #(
        .CODE_W(CODE_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_i  (bus_i),
        .wr_open(wr_open),
        .ld_low (ld_low),
        .clr_low(clr_low),
        .code_o (code_o),
        .upd_o  (upd_o)
    );

    dbdac_hold_mon #(
        .HOLD_MIN(HOLD_MIN)
    ) u_hold_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_open(wr_open),
        .ld_low (ld_low),
        .viol_o (viol_o)
    );

    // Offset binary to two's complement: flip the top bit.
    assign bip_o = $signed({~code_o[MSB], code_o[MSB-1:0]});

endmodule

// File: rtl/dbdac_front_chk.sv
module dbdac_front_chk #(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     load_n,
    input logic                     zero_n,
    input logic [CODE_W-1:0]        code_o,
    input logic signed [CODE_W-1:0] bip_o,
    input logic                     upd_o,
    input logic                     viol_o
);

    localparam int LAT = SYNC_STAGES + 2;
    localparam int MID = 1 << (CODE_W - 1);

    // R6: signed view equals code minus mid-scale.
    a_r6_bipolar_offset: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bip_o) == int'(code_o) - MID);

    // R7: update pulse marks exactly the cycles where the code moved.
    a_r7_upd_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o == (code_o != $past(code_o)));

    // R3: no load and no zero one latency window back means no change.
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_n, LAT) && $past(zero_n, LAT)) |-> $stable(code_o));

    // R4: a zero sampled one latency window back has cleared the code.
    a_r4_zero_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(zero_n, LAT) == 1'b0) |-> (code_o == '0));

    // R8: the violation flag is a single-cycle pulse.
    a_r8_viol_single: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |=> !viol_o);

endmodule

bind dbdac_front dbdac_front_chk #(
    .CODE_W     (CODE_W),
    .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .load_n(load_n),
    .zero_n(zero_n),
    .code_o(code_o),
    .bip_o (bip_o),
    .upd_o (upd_o),
    .viol_o(viol_o)
);

// File: tb/dbdac_front_bench.sv
`timescale 1ns/1ps
module dbdac_front_bench;

    localparam int W        = 12;
    localparam int HOLD_MIN = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [W-1:0]        bus_i = '0;
    logic                sel_n = 1'b1, wstb_n = 1'b1, load_n = 1'b1, zero_n = 1'b1;
    logic [W-1:0]        code_o;
    logic signed [W-1:0] bip_o;
    logic                upd_o, viol_o;

    int n_chk = 0, n_bad = 0;
    int upd_cnt = 0, viol_cnt = 0;
    logic [W-1:0] exp_in = '0, exp_dac = '0;

    always #2.5 clk = ~clk;

    dbdac_front #(.CODE_W(W), .SYNC_STAGES(2), .HOLD_MIN(HOLD_MIN)) u_dbdac_front (
        .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .sel_n(sel_n), .wstb_n(wstb_n),
        .load_n(load_n), .zero_n(zero_n), .code_o(code_o), .bip_o(bip_o),
        .upd_o(upd_o), .viol_o(viol_o));

    always @(negedge clk) begin
        if (rst_n && upd_o)  upd_cnt++;
        if (rst_n && viol_o) viol_cnt++;
    end

    function automatic int exp_bip(input logic [W-1:0] c);
        return int'(c) - 2048;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic [W-1:0] v, input bit s_low, input bit w_low);
        bus_i = v; sel_n = !s_low; wstb_n = !w_low;
        idle(4);
        sel_n = 1'b1; wstb_n = 1'b1;
        idle(4);
        bus_i = W'($urandom);
        if (s_low && w_low) exp_in = v;
        idle(4);
    endtask

    task automatic load();
        load_n = 1'b0; idle(4); load_n = 1'b1; idle(5);
        exp_dac = exp_in;
    endtask

    task automatic zero_pulse();
        zero_n = 1'b0; idle(4); zero_n = 1'b1; idle(5);
        exp_dac = '0;
    endtask

    task automatic check_code(input string req);
        check(code_o == exp_dac, req, int'(code_o), int'(exp_dac));
        check(int'(bip_o) == exp_bip(exp_dac), "R6", int'(bip_o), exp_bip(exp_dac));
    endtask

    task automatic overlap(input logic [W-1:0] v, input int gap, input int exp_v);
        int v0;
        v0 = viol_cnt;
        bus_i = v; sel_n = 1'b0; wstb_n = 1'b0; load_n = 1'b0;
        idle(5);
        sel_n = 1'b1; wstb_n = 1'b1;
        idle(gap);
        load_n = 1'b1;
        idle(8);
        exp_in = v; exp_dac = v;
        check(viol_cnt - v0 == exp_v, "R8 gap", viol_cnt - v0, exp_v);
        check_code("R3 overlap");
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int u0, v0;
        logic [W-1:0] prev;
        void'($urandom(32'd2718));
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check(code_o == 0, "R1 code", int'(code_o), 0);
        check(int'(bip_o) == -2048, "R1 bip", int'(bip_o), -2048);
        check(!upd_o && !viol_o, "R1 flags", int'({upd_o, viol_o}), 0);

        // R2 and R3: write without load leaves code alone
        write(12'h5A3, 1, 1);
        check_code("R3 no load");
        load();
        check_code("R2 hold after write");
        // R2: half-strobed writes are ignored
        write(12'h0F0, 0, 1);
        write(12'h777, 1, 0);
        load();
        check_code("R2 ignored write");

        // R6 corner codes
        write(12'd2048, 1, 1); load(); check_code("R6 mid");
        check(int'(bip_o) == 0, "R6 mid zero", int'(bip_o), 0);
        write(12'd4095, 1, 1); load(); check_code("R6 top");
        check(int'(bip_o) == 2047, "R6 top", int'(bip_o), 2047);
        write(12'd0, 1, 1); load(); check_code("R6 bottom");
        check(int'(bip_o) == -2048, "R6 bottom", int'(bip_o), -2048);

        // R9 flow-through latency, R7 single update
        write(12'h321, 1, 1); load();
        u0 = upd_cnt;
        bus_i = 12'hABC; sel_n = 1'b0; wstb_n = 1'b0; load_n = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check(code_o == 12'h321, "R9 early", int'(code_o), 'h321);
        end
        @(negedge clk);
        check(code_o == 12'hABC, "R9 arrive", int'(code_o), 'hABC);
        idle(4);
        check(upd_cnt - u0 == 1, "R7 flow", upd_cnt - u0, 1);
        exp_in = 12'hABC; exp_dac = 12'hABC;

        // R5 momentary zero with both registers open, R4 latency
        zero_n = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check(code_o == 12'hABC, "R4 early", int'(code_o), 'hABC);
        end
        @(negedge clk);
        check(code_o == 0, "R4 lands", int'(code_o), 0);
        idle(3);
        zero_n = 1'b1;
        idle(8);
        check(code_o == 12'hABC, "R5 returns", int'(code_o), 'hABC);
        sel_n = 1'b1; wstb_n = 1'b1; load_n = 1'b1;
        idle(6);

        // R5 persistent zero while holding, then later load
        zero_pulse();
        check_code("R5 persist");
        idle(12);
        check_code("R5 still zero");
        load();
        check_code("R5 reload");

        // R8 violation thresholds
        overlap(12'h111, 1, 1);
        overlap(12'h222, HOLD_MIN - 1, 1);
        overlap(12'h333, HOLD_MIN, 0);
        v0 = viol_cnt;
        write(12'h444, 1, 1); load();
        check(viol_cnt == v0, "R8 no overlap", viol_cnt - v0, 0);

        // Constrained random sequence
        v0 = viol_cnt;
        for (int i = 0; i < 40; i++) begin
            int op;
            op = int'($urandom % 5);
            prev = exp_dac;
            u0 = upd_cnt;
            unique case (op)
                0: write(W'($urandom), 1, 1);
                1: write(W'($urandom), 0, 1);
                2: load();
                3: zero_pulse();
                default: begin write(W'($urandom), 1, 1); load(); end
            endcase
            check_code("R3 random");
            check(upd_cnt - u0 == int'(prev != exp_dac), "R7 random",
                  upd_cnt - u0, int'(prev != exp_dac));
        end
        check(viol_cnt == v0, "R8 random quiet", viol_cnt - v0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule